// File: doc/BRIEF.md
# ADC Start-of-Conversion and Track Sequencer

This block is the digital controller for a 12-bit successive-approximation converter. Software programs it through one 8-bit control/status register. That register selects the trigger source that begins a conversion: a software write, either of two timer-overflow pulses, or a rising edge on an external convert-start pin. It also selects how the sample-and-hold tracks the input before conversion. The block drives a trial code to the external DAC and reads back the result of the analog comparator, one bit per SAR clock. When the last bit is resolved, it raises a sticky completion flag.

The SAR clock is a one-cycle enable pulse on the system clock. In continuous-track mode the input is tracked whenever the converter is enabled and idle. In timed-track mode a trigger first opens a tracking window of three SAR clocks and conversion follows it. In pin-track mode, tracking lasts as long as the pin is low and conversion starts on its rising edge. The 12-bit result appears on two 8-bit data outputs, right- or left-justified.

All pins are plain control and status signals. The result is a register value that holds until the next conversion ends, so there is no stream interface and no back-pressure.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `reg_rdata`, `data_hi` and `data_lo` are all zero and `tracking` is 0.
- R2: When the enable bit (bit 7) is 0, every trigger is ignored and `tracking` is 0. Clearing enable during a conversion returns the block to idle one cycle later, and the completion flag is not set.
- R3: With the track-mode bit (bit 6) at 0, the start field (bits 3:2) picks the trigger: 00 a software start, 01 `tmr3_ovf`, 10 a rising edge of `cnv_pin`, 11 `tmr2_ovf`. A pulse on any source that is not selected starts nothing. While enabled and idle, `tracking` is 1.
- R4: With track mode 1 and start field 00, 01 or 11, a trigger opens a tracking phase of exactly 3 SAR clocks, and conversion follows it. Busy stays high for 15 SAR clocks in total. While idle in this mode, `tracking` is 0.
- R5: With track mode 1 and start field 10, `tracking` follows the synchronised pin being low. Conversion starts on the pin's rising edge, with no extra tracking phase. The pin passes through a two-flop synchroniser.
- R6: Writing 1 to the busy bit (bit 4) starts a conversion one cycle later, but only if the start field held after that write is 00. Writing 0 to it has no effect. Busy reads 1 during both the tracking phase and the conversion.
- R7: The completion flag (bit 5) is set in the cycle in which busy falls at the end of a conversion.
- R8: A register write of 0 to a flag bit (bit 5 or bit 1) clears that flag, and a write of 1 leaves it unchanged. If hardware sets a flag in the same cycle as a software clear, the flag ends up set.
- R9: A pulse on `win_hit` sets the window flag (bit 1). The flag then stays set through later conversions until software clears it.
- R10: A conversion takes 12 SAR clocks and resolves the result from MSB to LSB. `dac_code` presents the current trial code; the first trial is 0x800. A bit is kept when `cmp_in` is 1.
- R11: A trigger that arrives while busy is 1 is ignored. The busy time and the result are unchanged.
- R12: With the justify bit (bit 0) at 0, `data_hi` = {4'h0, res[11:8]} and `data_lo` = res[7:0]. With it at 1, `data_hi` = res[11:4] and `data_lo` = {res[3:0], 4'h0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sar_tick | input | 1 | SAR clock enable, one cycle wide |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| cnv_pin | input | 1 | External convert-start pin, asynchronous |
| win_hit | input | 1 | Window-match pulse that sets the window flag |
| cmp_in | input | 1 | Comparator result: input is at or above the trial code |
| dac_code | output | 12 | Trial code for the DAC |
| tracking | output | 1 | Sample-and-hold tracking control |
| data_hi | output | 8 | High data byte of the justified result |
| data_lo | output | 8 | Low data byte of the justified result |

## Verification
The assertions check several properties on every cycle:
- The tracking counter never reaches its limit.
- Shutdown forces the sequencer back to idle.
- A trigger that lands during a conversion leaves the conversion running.
- Hardware flag sets take priority over software clears.
- The completion flag is present whenever busy falls while the block is enabled.

Other behaviour shows only in the bench's scenarios:
- That each start-field code answers to the correct source and to no other.
- That busy lasts 12 or 15 SAR clocks.
- That the SAR search lands on the analog value.
- That the two justified byte layouts are correct.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SRC_SW  = 2'b00,
    SRC_T3  = 2'b01,
    SRC_PIN = 2'b10,
    SRC_T2  = 2'b11
  } start_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_TRACK = 2'b01,
    ST_CONV  = 2'b10
  } eng_state_e;

  typedef struct packed {
    logic       en;
    logic       tmode;
    start_src_e src;
    logic       ljust;
  } ctl_cfg_t;

  localparam int BIT_EN    = 7;
  localparam int BIT_TMODE = 6;
  localparam int BIT_DONE  = 5;
  localparam int BIT_BUSY  = 4;
  localparam int BIT_SRC_H = 3;
  localparam int BIT_SRC_L = 2;
  localparam int BIT_WIN   = 1;
  localparam int BIT_LJ    = 0;

endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       done_set,
  input  logic       win_set,
  output ctl_cfg_t   cfg,
  output logic       sw_go,
  output logic [7:0] rdata
);

  logic       en_q, tm_q, lj_q, done_q, win_q, go_q;
  start_src_e src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tm_q   <= 1'b0;
      lj_q   <= 1'b0;
      src_q  <= SRC_SW;
      done_q <= 1'b0;
      win_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q <= wr && wdata[BIT_BUSY];
      if (wr) begin
        en_q  <= wdata[BIT_EN];
        tm_q  <= wdata[BIT_TMODE];
        lj_q  <= wdata[BIT_LJ];
        src_q <= start_src_e'(wdata[BIT_SRC_H:BIT_SRC_L]);
      end
      // hardware set takes priority over a software clear
      if (done_set)                    done_q <= 1'b1;
      else if (wr && !wdata[BIT_DONE]) done_q <= 1'b0;
      if (win_set)                     win_q  <= 1'b1;
      else if (wr && !wdata[BIT_WIN])  win_q  <= 1'b0;
    end
  end

  assign cfg   = '{en: en_q, tmode: tm_q, src: src_q, ljust: lj_q};
  assign sw_go = go_q;
  assign rdata = {en_q, tm_q, done_q, busy, src_q, win_q, lj_q};

  assert_done_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_q);
  assert_done_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[BIT_DONE] && !done_set) |=> !done_q);
  assert_win_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !(wr && !wdata[BIT_WIN])) |=> win_q);

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_cfg_t cfg,
  input  logic     sw_go,
  input  logic     t3_pulse,
  input  logic     t2_pulse,
  input  logic     pin_async,
  output logic     trig,
  output logic     pin_low
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s, pin_rise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= pin_async;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign pin_rise = pin_s && !prev_q;
  assign pin_low  = !pin_s;

  always_comb begin
    unique case (cfg.src)
      SRC_SW:  trig = sw_go;
      SRC_T3:  trig = t3_pulse;
      SRC_PIN: trig = pin_rise;
      SRC_T2:  trig = t2_pulse;
      default: trig = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int TRACK_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tmode,
  input  logic             pin_mode,
  input  logic             pin_low,
  input  logic             trig,
  input  logic             tick,
  input  logic             cmp,
  output logic             busy,
  output logic             done,
  output logic             track_now,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam int CNT_W = $clog2(TRACK_TICKS + 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRACK_TICKS - 1);

  eng_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] sar_q, sar_next, trial, result_q;
  logic             last_bit;

  always_comb begin
    sar_next        = sar_q;
    sar_next[idx_q] = cmp;
    trial           = sar_q;
    trial[idx_q]    = 1'b1;
  end

  assign last_bit = (idx_q == '0);
  assign done     = en && (state_q == ST_CONV) && tick && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= IDX_TOP;
      cnt_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
    end else if (!en) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig) begin
          sar_q   <= '0;
          idx_q   <= IDX_TOP;
          cnt_q   <= '0;
          state_q <= (tmode && !pin_mode) ? ST_TRACK : ST_CONV;
        end
        ST_TRACK: if (tick) begin
          if (cnt_q == CNT_LAST) state_q <= ST_CONV;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_CONV: if (tick) begin
          sar_q <= sar_next;
          if (last_bit) begin
            result_q <= sar_next;
            state_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign dac_code  = (state_q == ST_CONV) ? trial : '0;
  assign result    = result_q;
  assign track_now = (state_q == ST_TRACK) ||
                     (en && (state_q == ST_IDLE) && (!tmode || (pin_mode && pin_low)));

  assert_track_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRACK) |-> (cnt_q < CNT_W'(TRACK_TICKS)));
  assert_shutdown_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ST_IDLE));
  assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_CONV && trig && !(tick && last_bit)) |=> (state_q == ST_CONV));

endmodule

// File: rtl/adc_justify.sv
module adc_justify #(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0] result,
  input  logic             ljust,
  output logic [7:0]       hi,
  output logic [7:0]       lo
);

  localparam int PAD = 16 - RES_W;

  logic [15:0] right_w, left_w, sel_w;

  if (PAD == 0) begin : g_full
    assign right_w = result;
    assign left_w  = result;
  end else begin : g_pad
    assign right_w = {{PAD{1'b0}}, result};
    assign left_w  = {result, {PAD{1'b0}}};
  end

  assign sel_w = ljust ? left_w : right_w;
  assign hi    = sel_w[15:8];
  assign lo    = sel_w[7:0];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int TRACK_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sar_tick,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             tmr3_ovf,
  input  logic             tmr2_ovf,
  input  logic             cnv_pin,
  input  logic             win_hit,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             tracking,
  output logic [7:0]       data_hi,
  output logic [7:0]       data_lo
);

  ctl_cfg_t         cfg;
  logic             sw_go, trig, pin_low, busy, done;
  logic [RES_W-1:0] result;

  adc_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .done_set (done),
    .win_set  (win_hit),
    .cfg      (cfg),
    .sw_go    (sw_go),
    .rdata    (reg_rdata)
  );

  adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .sw_go     (sw_go),
    .t3_pulse  (tmr3_ovf),
    .t2_pulse  (tmr2_ovf),
    .pin_async (cnv_pin),
    .trig      (trig),
    .pin_low   (pin_low)
  );

  adc_sar_engine #(.RES_W(RES_W), .TRACK_TICKS(TRACK_TICKS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .tmode     (cfg.tmode),
    .pin_mode  (cfg.src == SRC_PIN),
    .pin_low   (pin_low),
    .trig      (trig),
    .tick      (sar_tick),
    .cmp       (cmp_in),
    .busy      (busy),
    .done      (done),
    .track_now (tracking),
    .dac_code  (dac_code),
    .result    (result)
  );

  adc_justify #(.RES_W(RES_W)) u_just (
    .result (result),
    .ljust  (cfg.ljust),
    .hi     (data_hi),
    .lo     (data_lo)
  );

  assert_done_on_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[BIT_BUSY]) && $past(reg_rdata[BIT_EN])) |-> reg_rdata[BIT_DONE]);

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sar_tick = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        tmr3_ovf = 1'b0, tmr2_ovf = 1'b0, cnv_pin = 1'b1, win_hit = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        tracking;
  logic [7:0]  data_hi, data_lo;
  logic [11:0] vin = '0;
  logic        slow = 1'b0;
  int          div = 0;
  int          checks = 0, failures = 0;

  // bit 15 track mode, 14:13 start field, 12 justify, 11:0 analog value
  localparam logic [15:0] VEC [8] = '{
    16'h0A5C, 16'h3123, 16'h4FFF, 16'h7000,
    16'h9801, 16'hA7FE, 16'hD3C3, 16'hEC0F
  };

  always #(CLK_P/2) clk = ~clk;

  assign cmp_in = (dac_code <= vin);

  always @(negedge clk) begin
    if (slow) begin
      div      = (div == 2) ? 0 : div + 1;
      sar_tick = (div == 0);
    end else begin
      sar_tick = 1'b1;
    end
  end

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sar_tick(sar_tick), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr3_ovf(tmr3_ovf),
    .tmr2_ovf(tmr2_ovf), .cnv_pin(cnv_pin), .win_hit(win_hit), .cmp_in(cmp_in),
    .dac_code(dac_code), .tracking(tracking), .data_hi(data_hi), .data_lo(data_lo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_t3();
    tmr3_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0;
  endtask

  task automatic pulse_t2();
    tmr2_ovf = 1'b1; @(negedge clk); tmr2_ovf = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      if (reg_rdata[4]) n++;
      else if (n > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic busy_seen(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      if (reg_rdata[4]) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] cfgb;
    logic       tm, lj;
    logic [1:0] md;
    logic [11:0] v;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 data_hi", data_hi, 8'h00);
    chk("R1 data_lo", data_lo, 8'h00);
    chk("R1 tracking", tracking, 1'b0);

    // R2 disabled: triggers ignored
    wr_reg(8'h04);
    pulse_t3();
    wr_reg(8'h10);
    busy_seen(20, n);
    chk("R2 disabled busy", n, 0);
    chk("R2 disabled tracking", tracking, 1'b0);

    // vector walk
    for (int k = 0; k < 8; k++) begin
      tm = VEC[k][15]; md = VEC[k][14:13]; lj = VEC[k][12]; v = VEC[k][11:0];
      vin  = v;
      cfgb = {1'b1, tm, 1'b0, 1'b0, md, 1'b0, lj};
      if (md == 2'b10) begin
        cnv_pin = 1'b0;
        idle(4);
      end
      wr_reg(cfgb);
      idle(1);
      if (md == 2'b10 && tm) chk("R5 tracking while pin low", tracking, 1'b1);
      if (md == 2'b10 && !tm) chk("R3 pin low no start", reg_rdata[4], 1'b0);
      unique case (md)
        2'b00: wr_reg(cfgb | 8'h10);
        2'b01: pulse_t3();
        2'b10: cnv_pin = 1'b1;
        default: pulse_t2();
      endcase
      busy_len(n);
      chk((tm && md != 2'b10) ? "R4 busy length timed" : "R10 busy length", n,
          (tm && md != 2'b10) ? 15 : 12);
      chk("R7 completion flag", reg_rdata[5], 1'b1);
      chk("R12 data_hi", data_hi, lj ? v[11:4] : {4'h0, v[11:8]});
      chk("R12 data_lo", data_lo, lj ? {v[3:0], 4'h0} : v[7:0]);
      chk(tm ? "R4 idle tracking" : "R3 idle tracking", tracking, !tm);
    end

    // R6 write 0 to busy: no start; busy=1 with non-00 field: no start
    vin = 12'h555;
    wr_reg(8'h80);
    busy_seen(20, n);
    chk("R6 write zero no effect", n, 0);
    wr_reg(8'h94);
    busy_seen(20, n);
    chk("R6 start needs field 00", n, 0);

    // R3 unselected source ignored (field 01, pulse timer 2)
    wr_reg(8'h84);
    pulse_t2();
    busy_seen(20, n);
    chk("R3 unselected source", n, 0);

    // R10 first trial code is MSB
    pulse_t3();
    chk("R10 first trial", dac_code, 12'h800);
    busy_len(n);
    chk("R10 result 555", {data_hi[3:0], data_lo}, 12'h555);

    // R11 retrigger during conversion ignored
    vin = 12'h3A9;
    wr_reg(8'h84);
    pulse_t3();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (reg_rdata[4]) n++;
      tmr3_ovf = (i == 4) || (i == 9);
      @(negedge clk);
    end
    tmr3_ovf = 1'b0;
    chk("R11 busy length with retrigger", n, 12);
    chk("R11 result", {data_hi[3:0], data_lo}, 12'h3A9);

    // R8 flag write semantics
    chk("R8 flag set before", reg_rdata[5], 1'b1);
    wr_reg(8'hA4);
    chk("R8 write one keeps", reg_rdata[5], 1'b1);
    wr_reg(8'h84);
    chk("R8 write zero clears", reg_rdata[5], 1'b0);

    // R9 window flag sticky
    win_hit = 1'b1; @(negedge clk); win_hit = 1'b0;
    chk("R9 window set", reg_rdata[1], 1'b1);
    pulse_t3();
    busy_len(n);
    chk("R9 sticky over conversion", reg_rdata[1], 1'b1);
    wr_reg(8'hA6);
    chk("R8 window write one keeps", reg_rdata[1], 1'b1);
    wr_reg(8'hA4);
    chk("R8 window write zero clears", reg_rdata[1], 1'b0);

    // R2 abort by clearing enable
    wr_reg(8'h84);
    pulse_t3();
    idle(4);
    wr_reg(8'h04);
    idle(1);
    chk("R2 abort busy", reg_rdata[4], 1'b0);
    idle(15);
    chk("R2 abort no flag", reg_rdata[5], 1'b0);

    // R10 slow SAR clock
    vin  = 12'hB6D;
    slow = 1'b1;
    wr_reg(8'h84);
    pulse_t3();
    busy_len(n);
    chk("R10 slow tick busy >= 34", (n >= 34), 1'b1);
    chk("R10 slow tick result", {data_hi[3:0], data_lo}, 12'hB6D);
    slow = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule